// File: doc/BRIEF.md
# I2C Slave Address and Receive Engine

This block is the receive side of an I2C slave. It watches oversampled SCL and SDA lines and finds START, repeated START and STOP conditions. It then shifts in each byte and compares the address phase against an address register that the host writes. In 7-bit mode the address is one byte. In 10-bit mode it is two bytes. When the byte is for this slave, the block pulls SDA low to acknowledge and moves the byte into a receive buffer. It also keeps four flags for the host: buffer-full, overflow, update-address and interrupt.

The acknowledge and the buffer transfer follow a fixed table driven by buffer-full and overflow. This lets a slow host see that it lost a byte, and the master gets a NACK for that byte.

In 10-bit mode the block holds SCL low after each address byte. The host then loads the next compare value into the address register, and that write releases the clock. The sequence is:
- Load the high pattern `11110 A9 A8 0`.
- Load the low address byte.
- Load the high pattern again so that a later repeated START can match.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset, bufFull, overflow, irqFlag and updAddr are 0, and neither sdaDriveLow nor sclHoldLow is asserted.
- R2: Bits clocked without a preceding START give no ACK and set no flag. While enable is 0 the whole bus is ignored.
- R3: In 7-bit mode (tenBitMode=0), the first byte after START is shifted MSB first on SCL rising edges. Its upper seven bits are compared with addrWrData[7:1] of the last address write. On a match with buffer-full and overflow clear, SDA is held low for the 9th clock, the byte (address in bits 7:1, R/W in bit 0) appears on bufData and bufFull is set. A mismatch gives no ACK and no flag change.
- R4: irqFlag stays 0 while the ACK clock is high. It rises only after the falling edge of the 9th SCL pulse of a byte addressed to this slave.
- R5: A received byte with bufFull=0 and overflow=0 is acknowledged, is copied to bufData, sets bufFull and sets irqFlag.
- R6: A received byte with bufFull=1 and overflow=0 is not acknowledged and leaves bufData unchanged. It sets overflow and irqFlag.
- R7: A received byte with overflow=1 is not acknowledged and leaves bufData and bufFull unchanged. It still sets irqFlag, and overflow stays 1.
- R8: A bufRd pulse clears bufFull only. An irqClr pulse clears irqFlag only. An ovClr pulse clears overflow only.
- R9: In 10-bit mode a first byte of the form `11110 A9 A8 0` whose bits 7:1 equal the address register is acknowledged. After the 9th falling edge it sets updAddr and asserts sclHoldLow. A first byte with R/W=1 that does not follow a complete 10-bit match is not acknowledged.
- R10: sclHoldLow stays asserted until the host writes the address register. That write clears updAddr and releases SCL.
- R11: In 10-bit mode the second address byte must equal all 8 bits of the address register to be acknowledged. A match sets updAddr and holds SCL again. A mismatch gives no ACK and no flag.
- R12: After a full 10-bit match, a repeated START followed by the high byte with R/W=1 is acknowledged and sets irqFlag and bufFull. It leaves updAddr clear and does not hold SCL.
- R13: A STOP returns the block to idle and releases SDA and SCL. Later bits without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; when low the bus is ignored |
| tenBitMode | input | 1 | 1 selects two-byte 10-bit addressing |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad |
| sdaDriveLow | output | 1 | Pull SDA low (acknowledge) |
| sclHoldLow | output | 1 | Pull SCL low (clock stretch) |
| addrWr | input | 1 | Host write strobe for the address register |
| addrWrData | input | 8 | Host write data for the address register |
| bufRd | input | 1 | Host read strobe for the receive buffer |
| irqClr | input | 1 | Host clear of the interrupt flag |
| ovClr | input | 1 | Host clear of the overflow flag |
| bufData | output | 8 | Receive buffer contents |
| bufFull | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| irqFlag | output | 1 | Interrupt flag, set once per addressed byte |
| updAddr | output | 1 | Host must reload the address register (10-bit) |

## Verification
The assertions take for granted that SDA changes only while SCL is low, except when the master deliberately forms a START or STOP. They also assume that every SCL and SDA level lasts longer than the two-stage synchroniser plus one edge-detect register. A third assumption is that the host never reads the buffer or writes the address register in the same clock that a byte decision lands. The bench master holds each bus phase for a dozen clocks. It changes SDA only in the low phase, and before raising SCL it waits for any clock stretch to end. All host strobes are issued only between bytes, after the ninth falling edge has settled.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDRLO,
    ST_DATA,
    ST_SKIP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic xfer;
    logic setOv;
    logic ackOn;
    logic ackOff;
    logic raiseIrq;
    logic raiseUpd;
    logic releaseAll;
  } rxStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic bufFull;
    logic overflow;
    logic hiMatch;
    logic fullMatch;
    logic rwBit;
  } rxStatus_t;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclPipe;
  logic [TOP:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[TOP-1:0], sclIn};
      sdaPipe <= {sdaPipe[TOP-1:0], sdaIn};
      sclPrev <= sclPipe[TOP];
      sdaPrev <= sdaPipe[TOP];
    end
  end

  assign sclNow   = sclPipe[TOP];
  assign sdaNow   = sdaPipe[TOP];
  assign sdaBit   = sdaNow;
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

endmodule

// File: rtl/i2c_rx_dp.sv
module i2c_rx_dp
  import i2c_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              sdaBit,
  input  logic              addrWr,
  input  logic [BYTE_W-1:0] addrWrData,
  input  logic              bufRd,
  input  logic              irqClr,
  input  logic              ovClr,
  output rxStatus_t         status,
  output logic [BYTE_W-1:0] bufData,
  output logic              bufFull,
  output logic              overflow,
  output logic              irqFlag,
  output logic              updAddr,
  output logic              sdaDriveLow,
  output logic              sclHoldLow
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] bufReg;
  logic [BYTE_W-1:0] ownAddr;
  logic bfReg, ovReg, irqReg, updReg, holdReg, sdaReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bufReg   <= '0;
      ownAddr  <= RESET_ADDR;
    end else begin
      if (stb.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      if (stb.xfer)    bufReg   <= shiftReg;
      if (addrWr)      ownAddr  <= addrWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bfReg   <= 1'b0;
      ovReg   <= 1'b0;
      irqReg  <= 1'b0;
      updReg  <= 1'b0;
      holdReg <= 1'b0;
      sdaReg  <= 1'b0;
    end else begin
      if (stb.xfer)          bfReg <= 1'b1;
      else if (bufRd)        bfReg <= 1'b0;

      if (stb.setOv)         ovReg <= 1'b1;
      else if (ovClr)        ovReg <= 1'b0;

      if (stb.raiseIrq)      irqReg <= 1'b1;
      else if (irqClr)       irqReg <= 1'b0;

      if (stb.raiseUpd)      updReg <= 1'b1;
      else if (addrWr)       updReg <= 1'b0;

      if (stb.raiseUpd)                   holdReg <= 1'b1;
      else if (addrWr || stb.releaseAll)  holdReg <= 1'b0;

      if (stb.ackOn)                       sdaReg <= 1'b1;
      else if (stb.ackOff || stb.releaseAll) sdaReg <= 1'b0;
    end
  end

  assign status.bufFull   = bfReg;
  assign status.overflow  = ovReg;
  assign status.hiMatch   = (shiftReg[BYTE_W-1:1] == ownAddr[BYTE_W-1:1]);
  assign status.fullMatch = (shiftReg == ownAddr);
  assign status.rwBit     = shiftReg[0];

  assign bufData     = bufReg;
  assign bufFull     = bfReg;
  assign overflow    = ovReg;
  assign irqFlag     = irqReg;
  assign updAddr     = updReg;
  assign sdaDriveLow = sdaReg;
  assign sclHoldLow  = holdReg;

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      tenBitMode,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  rxStatus_t status,
  output rxStrobe_t stb
);

  rxState_t state, stNxt, afterAck, afterNxt, candidate;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic ackPh, ackPhNxt;
  logic pendIrq, pendIrqNxt;
  logic pendUpd, pendUpdNxt;
  logic hiSeen, hiSeenNxt;
  logic take, matched, updWanted, keepOnNack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      ackPh    <= 1'b0;
      pendIrq  <= 1'b0;
      pendUpd  <= 1'b0;
      hiSeen   <= 1'b0;
    end else begin
      state    <= stNxt;
      afterAck <= afterNxt;
      bitCnt   <= cntNxt;
      ackPh    <= ackPhNxt;
      pendIrq  <= pendIrqNxt;
      pendUpd  <= pendUpdNxt;
      hiSeen   <= hiSeenNxt;
    end
  end

  // per-state view of the byte just shifted in
  always_comb begin
    matched    = 1'b0;
    updWanted  = 1'b0;
    keepOnNack = 1'b0;
    candidate  = ST_SKIP;
    case (state)
      ST_ADDR: begin
        if (tenBitMode) begin
          if (hiSeen && status.rwBit) begin
            matched   = status.hiMatch;
            candidate = ST_SKIP;
          end else begin
            matched   = status.hiMatch && !status.rwBit;
            updWanted = 1'b1;
            candidate = ST_ADDRLO;
          end
        end else begin
          matched   = status.hiMatch;
          candidate = status.rwBit ? ST_SKIP : ST_DATA;
        end
      end
      ST_ADDRLO: begin
        matched   = status.fullMatch;
        updWanted = 1'b1;
        candidate = ST_DATA;
      end
      ST_DATA: begin
        matched    = 1'b1;
        keepOnNack = 1'b1;
        candidate  = ST_DATA;
      end
      default: ;
    endcase
  end

  assign take = !status.bufFull && !status.overflow;

  always_comb begin
    stb        = '0;
    stNxt      = state;
    afterNxt   = afterAck;
    cntNxt     = bitCnt;
    ackPhNxt   = ackPh;
    pendIrqNxt = pendIrq;
    pendUpdNxt = pendUpd;
    hiSeenNxt  = hiSeen;

    if (!enable || stopDet) begin
      stNxt          = ST_IDLE;
      cntNxt         = '0;
      ackPhNxt       = 1'b0;
      pendIrqNxt     = 1'b0;
      pendUpdNxt     = 1'b0;
      hiSeenNxt      = 1'b0;
      stb.releaseAll = 1'b1;
    end else if (startDet) begin
      stNxt      = ST_ADDR;
      cntNxt     = '0;
      ackPhNxt   = 1'b0;
      pendIrqNxt = 1'b0;
      pendUpdNxt = 1'b0;
      stb.ackOff = 1'b1;
    end else if (state != ST_IDLE) begin
      if (sclRise && !ackPh && (bitCnt < CNT_W'(BYTE_W))) begin
        stb.shiftIn = 1'b1;
        cntNxt      = bitCnt + 1'b1;
      end
      if (sclFall) begin
        if (ackPh) begin
          // falling edge of the ninth pulse
          stb.ackOff   = 1'b1;
          stb.raiseIrq = pendIrq;
          stb.raiseUpd = pendUpd;
          stNxt        = afterAck;
          cntNxt       = '0;
          ackPhNxt     = 1'b0;
          pendIrqNxt   = 1'b0;
          pendUpdNxt   = 1'b0;
        end else if (bitCnt == CNT_W'(BYTE_W)) begin
          // falling edge of the eighth pulse: decide
          ackPhNxt = 1'b1;
          afterNxt = ST_SKIP;
          if (matched) begin
            pendIrqNxt = 1'b1;
            pendUpdNxt = updWanted && take;
            if (take) begin
              stb.xfer  = 1'b1;
              stb.ackOn = 1'b1;
              afterNxt  = candidate;
            end else begin
              stb.setOv = !status.overflow;
              afterNxt  = keepOnNack ? candidate : ST_SKIP;
            end
            if (state == ST_ADDRLO) hiSeenNxt = 1'b1;
          end else if (state == ST_ADDR) begin
            hiSeenNxt = 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx
  import i2c_rx_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RESET_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tenBitMode,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic              sclHoldLow,
  input  logic              addrWr,
  input  logic [BYTE_W-1:0] addrWrData,
  input  logic              bufRd,
  input  logic              irqClr,
  input  logic              ovClr,
  output logic [BYTE_W-1:0] bufData,
  output logic              bufFull,
  output logic              overflow,
  output logic              irqFlag,
  output logic              updAddr
);

  logic sdaBitW, sclRiseW, sclFallW, startDetW, stopDetW;
  rxStrobe_t stbW;
  rxStatus_t statusW;

  i2c_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sdaBit   (sdaBitW),
    .sclRise  (sclRiseW),
    .sclFall  (sclFallW),
    .startDet (startDetW),
    .stopDet  (stopDetW)
  );

  i2c_rx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .tenBitMode (tenBitMode),
    .sclRise    (sclRiseW),
    .sclFall    (sclFallW),
    .startDet   (startDetW),
    .stopDet    (stopDetW),
    .status     (statusW),
    .stb        (stbW)
  );

  i2c_rx_dp #(.RESET_ADDR(RESET_ADDR)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stbW),
    .sdaBit      (sdaBitW),
    .addrWr      (addrWr),
    .addrWrData  (addrWrData),
    .bufRd       (bufRd),
    .irqClr      (irqClr),
    .ovClr       (ovClr),
    .status      (statusW),
    .bufData     (bufData),
    .bufFull     (bufFull),
    .overflow    (overflow),
    .irqFlag     (irqFlag),
    .updAddr     (updAddr),
    .sdaDriveLow (sdaDriveLow),
    .sclHoldLow  (sclHoldLow)
  );

endmodule

// File: rtl/i2c_addr_rx_chk.sv
module i2c_addr_rx_chk (
  input logic clk,
  input logic rstN,
  input logic sclFall,
  input logic stopDet,
  input logic tenBitMode,
  input logic bufRd,
  input logic sdaDriveLow,
  input logic sclHoldLow,
  input logic bufFull,
  input logic overflow,
  input logic irqFlag,
  input logic updAddr
);

  // R3
  ack_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> $past(sclFall));

  // R4
  irq_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(sclFall));

  // R5
  bf_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(sclFall));

  // R6
  ov_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(bufFull));

  // R8
  bf_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufFull) |-> $past(bufRd));

  // R10
  hold_implies_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclHoldLow |-> updAddr);

  // R9
  upd_only_tenbit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updAddr) |-> tenBitMode);

  // R13
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaDriveLow && !sclHoldLow));

endmodule

bind i2c_addr_rx i2c_addr_rx_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclFall     (sclFallW),
  .stopDet     (stopDetW),
  .tenBitMode  (tenBitMode),
  .bufRd       (bufRd),
  .sdaDriveLow (sdaDriveLow),
  .sclHoldLow  (sclHoldLow),
  .bufFull     (bufFull),
  .overflow    (overflow),
  .irqFlag     (irqFlag),
  .updAddr     (updAddr)
);

// File: tb/i2c_addr_rx_bench.sv
`timescale 1ns/1ps
module i2c_addr_rx_bench;

  localparam int HALF = 12;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic tenBitMode = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic addrWr = 1'b0;
  logic [7:0] addrWrData = '0;
  logic bufRd = 1'b0;
  logic irqClr = 1'b0;
  logic ovClr = 1'b0;
  logic sdaDriveLow, sclHoldLow;
  logic [7:0] bufData;
  logic bufFull, overflow, irqFlag, updAddr;
  logic sclLine, sdaLine;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic irqAtAck;

  always #5 clk = ~clk;

  assign sclLine = mScl & ~sclHoldLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  i2c_addr_rx u_i2c_addr_rx (
    .clk(clk), .rstN(rstN), .enable(enable), .tenBitMode(tenBitMode),
    .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .sclHoldLow(sclHoldLow),
    .addrWr(addrWr), .addrWrData(addrWrData),
    .bufRd(bufRd), .irqClr(irqClr), .ovClr(ovClr),
    .bufData(bufData), .bufFull(bufFull), .overflow(overflow),
    .irqFlag(irqFlag), .updAddr(updAddr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclUp();
    mScl = 1'b1;
    tick(1);
    while (sclHoldLow) tick(1);
    tick(HALF);
  endtask

  task automatic sclDown();
    mScl = 1'b0;
    tick(HALF);
  endtask

  task automatic busStart();
    mSda = 1'b1;
    tick(HALF);
    sclUp();
    mSda = 1'b0;
    tick(HALF);
    sclDown();
  endtask

  task automatic busStop();
    mSda = 1'b0;
    tick(HALF);
    sclUp();
    mSda = 1'b1;
    tick(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i];
      tick(2);
      sclUp();
      sclDown();
    end
    mSda = 1'b1;
    tick(2);
    sclUp();
    acked = ~sdaLine;
    irqAtAck = irqFlag;
    sclDown();
  endtask

  task automatic pulse(input int which);
    case (which)
      0: bufRd = 1'b1;
      1: irqClr = 1'b1;
      default: ovClr = 1'b1;
    endcase
    tick(1);
    bufRd = 1'b0; irqClr = 1'b0; ovClr = 1'b0;
    tick(1);
  endtask

  task automatic hostClear();
    pulse(0);
    pulse(1);
  endtask

  task automatic addrWrite(input logic [7:0] v);
    addrWrData = v;
    addrWr = 1'b1;
    tick(1);
    addrWr = 1'b0;
    tick(2);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic acked;
    tick(5);
    // R1 reset state
    chk("R1 bufFull", bufFull, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 irqFlag", irqFlag, 0);
    chk("R1 updAddr", updAddr, 0);
    chk("R1 sdaDriveLow", sdaDriveLow, 0);
    chk("R1 sclHoldLow", sclHoldLow, 0);
    rstN = 1'b1;
    tick(3);

    // R2 disabled engine ignores a matching address
    addrWrite(8'hB4);
    busStart();
    sendByte(8'hB4, acked);
    chk("R2 ack while disabled", acked, 0);
    chk("R2 irq while disabled", irqFlag, 0);
    busStop();
    enable = 1'b1;
    tick(4);

    // R3 / R4 sweep of all 7-bit addresses against 0x5A
    for (int a = 0; a < 128; a++) begin
      logic hit;
      hit = (a == 'h5A);
      busStart();
      sendByte(8'(a << 1), acked);
      tick(4);
      chk("R3 ack", acked, hit);
      chk("R3 bufFull", bufFull, hit);
      chk("R4 irq after ninth fall", irqFlag, hit);
      if (hit) begin
        chk("R3 bufData", bufData, 8'hB4);
        chk("R4 irq during ack", irqAtAck, 0);
      end
      busStop();
      chk("R13 lines released", {sdaDriveLow, sclHoldLow}, 0);
      if (hit) begin
        hostClear();
        chk("R8 read clears bufFull", bufFull, 0);
        chk("R8 irqClr clears irq", irqFlag, 0);
      end
    end

    // R13 / R2 bits after STOP without START
    sclDown();
    sendByte(8'hB4, acked);
    chk("R13 no ack after stop", acked, 0);
    chk("R2 no irq without start", irqFlag, 0);
    busStop();

    // table of received-byte actions
    busStart();
    sendByte(8'hB4, acked);
    chk("R3 ack before data", acked, 1);
    hostClear();
    sendByte(8'h3C, acked);
    tick(4);
    chk("R5 ack", acked, 1);
    chk("R5 bufData", bufData, 8'h3C);
    chk("R5 bufFull", bufFull, 1);
    chk("R5 irq", irqFlag, 1);
    pulse(1);
    sendByte(8'h77, acked);
    tick(4);
    chk("R6 nack", acked, 0);
    chk("R6 bufData kept", bufData, 8'h3C);
    chk("R6 overflow", overflow, 1);
    chk("R6 irq", irqFlag, 1);
    pulse(1);
    sendByte(8'h11, acked);
    tick(4);
    chk("R7 nack full", acked, 0);
    chk("R7 bufData kept", bufData, 8'h3C);
    chk("R7 overflow kept", overflow, 1);
    chk("R7 irq", irqFlag, 1);
    pulse(1);
    pulse(0);
    chk("R8 read clears bufFull", bufFull, 0);
    chk("R8 read keeps overflow", overflow, 1);
    chk("R8 read keeps irq clear", irqFlag, 0);
    sendByte(8'h22, acked);
    tick(4);
    chk("R7 nack empty", acked, 0);
    chk("R7 bufFull stays 0", bufFull, 0);
    chk("R7 bufData kept", bufData, 8'h3C);
    chk("R7 irq", irqFlag, 1);
    pulse(1);
    pulse(2);
    chk("R8 ovClr clears overflow", overflow, 0);
    chk("R8 ovClr keeps bufFull", bufFull, 0);
    sendByte(8'h44, acked);
    tick(4);
    chk("R5 ack after clear", acked, 1);
    chk("R5 bufData", bufData, 8'h44);
    hostClear();
    busStop();

    // 10-bit high byte sweep: A9A8 patterns and fresh read request
    tenBitMode = 1'b1;
    addrWrite(8'hF4);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] hb;
      logic hit;
      hb = (k < 4) ? 8'(8'hF0 | (k << 1)) : 8'hF5;
      hit = (hb == 8'hF4);
      busStart();
      sendByte(hb, acked);
      tick(4);
      chk("R9 hi ack", acked, hit);
      chk("R9 updAddr", updAddr, hit);
      chk("R9 hold", sclHoldLow, hit);
      if (hit) begin
        hostClear();
        addrWrite(8'hF4);
        chk("R10 release", sclHoldLow, 0);
      end
      busStop();
    end

    // full 10-bit flow with repeated START
    busStart();
    sendByte(8'hF4, acked);
    tick(4);
    chk("R9 ack", acked, 1);
    chk("R9 updAddr", updAddr, 1);
    chk("R9 bufData", bufData, 8'hF4);
    chk("R4 irq after ninth fall", irqFlag, 1);
    chk("R4 irq during ack", irqAtAck, 0);
    tick(50);
    chk("R10 hold persists", {sclHoldLow, sclLine}, 2'b10);
    hostClear();
    chk("R10 hold until write", sclHoldLow, 1);
    addrWrite(8'hA5);
    chk("R10 upd cleared", updAddr, 0);
    chk("R10 hold released", sclHoldLow, 0);
    sendByte(8'hA5, acked);
    tick(4);
    chk("R11 lo ack", acked, 1);
    chk("R11 updAddr", updAddr, 1);
    chk("R11 hold", sclHoldLow, 1);
    chk("R11 bufData", bufData, 8'hA5);
    hostClear();
    addrWrite(8'hF4);
    sendByte(8'h5E, acked);
    tick(4);
    chk("R5 ten-bit data ack", acked, 1);
    chk("R5 ten-bit data", bufData, 8'h5E);
    chk("R5 no upd on data", updAddr, 0);
    hostClear();
    busStart();
    sendByte(8'hF5, acked);
    tick(4);
    chk("R12 ack", acked, 1);
    chk("R12 irq", irqFlag, 1);
    chk("R12 bufFull", bufFull, 1);
    chk("R12 bufData", bufData, 8'hF5);
    chk("R12 no upd", updAddr, 0);
    chk("R12 no hold", sclHoldLow, 0);
    hostClear();
    busStop();

    // wrong low byte
    busStart();
    sendByte(8'hF4, acked);
    tick(4);
    hostClear();
    addrWrite(8'hA5);
    sendByte(8'hA6, acked);
    tick(4);
    chk("R11 wrong lo nack", acked, 0);
    chk("R11 wrong lo irq", irqFlag, 0);
    chk("R11 wrong lo upd", updAddr, 0);
    busStop();
    chk("R13 idle after stop", {sdaDriveLow, sclHoldLow}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule